// File: doc/BRIEF.md
# Pattern-Gated Receive Bit FIFO

This block takes demodulated receive bits, each qualified by a one-cycle strobe from the clock recovery logic, and stores them in a 16-bit first-in first-out buffer. In the default mode the buffer stays closed until the last eight bits received since the fill was armed equal a programmed synchronisation byte. After that match, every later bit is stored. A mode input can instead open the buffer from the first strobed bit.

A host pops stored bits one at a time, oldest first. A level interrupt tells the host that enough bits are waiting. The programmed threshold is a 4-bit bit count. A sticky overflow flag reports any bit that was lost because the buffer was full. Two enables control the block. The FIFO enable gates all of its state and status outputs. The fill enable arms filling, and toggling it re-arms the pattern search.

Top module: `rx_sync_fifo`

## Requirements
- R1: The buffer holds 16 bits; sixteen bits pushed with no pop are all read back intact.
- R2: A pop on `pop_i` presents the oldest stored bit on `pop_bit_o` one cycle later and removes it. A pop while the buffer is empty leaves it unchanged and presents 0.
- R3: With `fill_always_i` = 0, no bit is stored until a match is found. A match is the last eight strobed bits since arming, oldest bit compared with bit 7 of `sync_pattern_i`, equal to the pattern, with at least eight bits seen. The bit that completes the match is not stored; the bits after it are.
- R4: A match stays latched while filling is armed, so later occurrences of the pattern are stored as plain data. Clearing and then setting `fill_en_i` restarts the search with an empty window.
- R5: With `fill_always_i` = 1, every strobed bit is stored, starting with the first one.
- R6: A bit strobed while 16 bits are held and no pop happens in the same cycle is dropped. The stored contents are preserved and `overflow_o` is set. The flag holds until `fill_en_i` or `fifo_en_i` goes low.
- R7: `fifo_irq_o` is high exactly while the stored count is at least the threshold. The threshold is the value of `irq_level_i` for values 1 to 15, and 16 for the value 0. The output drops as soon as pops take the count below the threshold.
- R8: While `fifo_en_i` is low, the buffer is flushed, the match is cleared, strobes are ignored, and `fifo_irq_o` and `overflow_o` are low.
- R9: While `fill_en_i` is low, strobed bits are not stored, but bits already stored are kept and can still be popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_bit_i | input | 1 | Recovered data bit |
| bit_stb_i | input | 1 | One-cycle strobe qualifying `rx_bit_i` |
| fifo_en_i | input | 1 | FIFO enable; low flushes and silences status |
| fill_en_i | input | 1 | Fill arm; a low-to-high transition restarts the pattern search |
| fill_always_i | input | 1 | 1: store every bit; 0: store only after a pattern match |
| irq_level_i | input | 4 | Interrupt threshold in bits (0 means 16) |
| sync_pattern_i | input | 8 | Synchronisation byte, first-received bit in bit 7 |
| pop_i | input | 1 | Pop the oldest stored bit |
| pop_bit_o | output | 1 | Last popped bit |
| fifo_irq_o | output | 1 | Level interrupt |
| overflow_o | output | 1 | Sticky overflow flag |

## Verification
A pattern window that is shifted wrongly or compared off by one moves the first stored bit. The bench sees this at once: with a threshold of one, the interrupt rises one strobe too early or too late. Broken pointer or count logic shows up as a misordered or missing bit on `pop_bit_o`, or as an interrupt edge at the wrong depth. Each threshold is swept against every fill depth, so a count error is visible within one strobe or pop. A drop on overflow that corrupts storage appears only when the buffer is drained, so the bench drains it completely and compares every bit.

// File: rtl/rx_sync_pkg.sv
package rx_sync_pkg;
  typedef enum logic {
    FILL_ON_SYNC = 1'b0,
    FILL_ALWAYS  = 1'b1
  } fill_mode_e;
endpackage

// File: rtl/rx_sync_detect.sv
module rx_sync_detect #(
  parameter int PAT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             stb_i,
  input  logic             bit_i,
  input  logic [PAT_W-1:0] pattern_i,
  output logic             hit_o
);
  localparam int CNT_W = $clog2(PAT_W + 1);

  logic [PAT_W-1:0] win_q;
  logic [CNT_W-1:0] seen_q;
  logic             hit_q;
  logic [PAT_W-1:0] win_next;
  logic             match;

  assign win_next = {win_q[PAT_W-2:0], bit_i};
  // window is full once this strobe brings PAT_W bits in
  assign match = (seen_q >= CNT_W'(PAT_W - 1)) && (win_next == pattern_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      seen_q <= '0;
      hit_q  <= 1'b0;
    end else if (!arm_i) begin
      win_q  <= '0;
      seen_q <= '0;
      hit_q  <= 1'b0;
    end else if (stb_i && !hit_q) begin
      win_q <= win_next;
      if (seen_q != CNT_W'(PAT_W)) seen_q <= seen_q + 1'b1;
      if (match) hit_q <= 1'b1;
    end
  end

  assign hit_o = hit_q;

  assert_hit_latched_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_q && arm_i) |=> hit_q);

  assert_disarm_clears_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> !hit_q);
endmodule

// File: rtl/rx_bit_fifo.sv
module rx_bit_fifo #(
  parameter int DEPTH = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clr_i,
  input  logic                       ovf_clr_i,
  input  logic                       wr_i,
  input  logic                       wr_bit_i,
  input  logic                       rd_i,
  output logic                       rd_bit_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic                       ovf_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;
  logic             ovf_q, rd_bit_q;
  logic             full, do_rd, do_wr, drop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (count_q == CNT_W'(DEPTH));
  assign do_rd = rd_i && (count_q != '0);
  assign do_wr = wr_i && (!full || do_rd);
  assign drop  = wr_i && full && !do_rd;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= 1'b0;
      else if (!clr_i && do_wr && (wr_ptr_q == PTR_W'(g))) mem_q[g] <= wr_bit_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      ovf_q    <= 1'b0;
      rd_bit_q <= 1'b0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      ovf_q    <= 1'b0;
      rd_bit_q <= 1'b0;
    end else begin
      if (do_wr) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (do_rd) rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({do_wr, do_rd})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
      if (ovf_clr_i)  ovf_q <= 1'b0;
      else if (drop)  ovf_q <= 1'b1;
      if (rd_i) rd_bit_q <= do_rd ? mem_q[rd_ptr_q] : 1'b0;
    end
  end

  assign rd_bit_o = rd_bit_q;
  assign count_o  = count_q;
  assign ovf_o    = ovf_q;

  assert_count_bound_R1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));

  assert_drop_preserves_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop && !clr_i && !ovf_clr_i) |=> (ovf_q && full && $stable(wr_ptr_q)));

  assert_pop_decrements_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_rd && !do_wr && !clr_i) |=> (count_q == $past(count_q) - 1'b1));
endmodule

// File: rtl/rx_fill_level.sv
module rx_fill_level #(
  parameter int DEPTH = 16,
  parameter int LVL_W = 4
) (
  input  logic                       en_i,
  input  logic [$clog2(DEPTH+1)-1:0] count_i,
  input  logic [LVL_W-1:0]           level_i,
  output logic                       irq_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int CMP_W = ((CNT_W > LVL_W) ? CNT_W : LVL_W) + 1;

  logic [CMP_W-1:0] thr, cnt;

  // a zero level means a full buffer
  assign thr   = (level_i == '0) ? CMP_W'(DEPTH) : CMP_W'(level_i);
  assign cnt   = CMP_W'(count_i);
  assign irq_o = en_i && (cnt >= thr);
endmodule

// File: rtl/rx_sync_fifo.sv
module rx_sync_fifo
  import rx_sync_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PAT_W = 8,
  parameter int LVL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_bit_i,
  input  logic             bit_stb_i,
  input  logic             fifo_en_i,
  input  logic             fill_en_i,
  input  logic             fill_always_i,
  input  logic [LVL_W-1:0] irq_level_i,
  input  logic [PAT_W-1:0] sync_pattern_i,
  input  logic             pop_i,
  output logic             pop_bit_o,
  output logic             fifo_irq_o,
  output logic             overflow_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  fill_mode_e       mode;
  logic             armed, sync_hit, wr, ovf;
  logic [CNT_W-1:0] count;

  assign mode  = fill_mode_e'(fill_always_i);
  assign armed = fifo_en_i && fill_en_i;
  assign wr    = bit_stb_i && armed && ((mode == FILL_ALWAYS) || sync_hit);

  rx_sync_detect #(.PAT_W(PAT_W)) u_detect (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (armed),
    .stb_i     (bit_stb_i),
    .bit_i     (rx_bit_i),
    .pattern_i (sync_pattern_i),
    .hit_o     (sync_hit)
  );

  rx_bit_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (!fifo_en_i),
    .ovf_clr_i (!fill_en_i),
    .wr_i      (wr),
    .wr_bit_i  (rx_bit_i),
    .rd_i      (pop_i && fifo_en_i),
    .rd_bit_o  (pop_bit_o),
    .count_o   (count),
    .ovf_o     (ovf)
  );

  rx_fill_level #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_level (
    .en_i    (fifo_en_i),
    .count_i (count),
    .level_i (irq_level_i),
    .irq_o   (fifo_irq_o)
  );

  assign overflow_o = ovf && fifo_en_i;

  assert_no_fill_before_sync_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode == FILL_ON_SYNC) && !sync_hit && bit_stb_i) |=> (count <= $past(count)));

  assert_disable_flushes_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en_i |=> ((count == '0) && !overflow_o && !fifo_irq_o));

  assert_fill_off_no_growth_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fill_en_i |=> (count <= $past(count)));
endmodule

// File: tb/rx_sync_fifo_tb.sv
module rx_sync_fifo_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_bit = 1'b0, stb = 1'b0, fifo_en = 1'b0, fill_en = 1'b0, fill_always = 1'b0;
  logic [3:0] level = 4'd1;
  logic [7:0] pattern = 8'hD4;
  logic       pop = 1'b0;
  logic       pop_bit, irq, ovf;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rx_sync_fifo dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rx_bit_i(rx_bit), .bit_stb_i(stb),
    .fifo_en_i(fifo_en), .fill_en_i(fill_en), .fill_always_i(fill_always),
    .irq_level_i(level), .sync_pattern_i(pattern), .pop_i(pop),
    .pop_bit_o(pop_bit), .fifo_irq_o(irq), .overflow_o(ovf)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic b);
    @(negedge clk); rx_bit = b; stb = 1'b1;
    @(negedge clk); stb = 1'b0;
  endtask

  task automatic pop_one(output logic b);
    @(negedge clk); pop = 1'b1;
    @(negedge clk); pop = 1'b0; b = pop_bit;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic flush();
    @(negedge clk); fifo_en = 1'b0; @(negedge clk); fifo_en = 1'b1;
  endtask

  function automatic logic sweep_bit(input int lv, input int i);
    return ((lv * 3 + i * i + i) % 5) > 1;
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        done = 1;
        errors++; checks++;
        $display("FAIL watchdog actual %0d expected %0d", cycles, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic b;
    logic s [24];
    idle(3);
    check("reset irq R8", int'(irq), 0);
    check("reset ovf R8", int'(ovf), 0);
    check("reset pop_bit R2", int'(pop_bit), 0);
    rst_n = 1'b1;
    idle(2);

    // R5 R7 R1 R2: every threshold against every fill depth
    fill_always = 1'b1; fill_en = 1'b1;
    for (int lv = 0; lv < 16; lv++) begin
      int thr;
      thr = (lv == 0) ? 16 : lv;
      level = 4'(lv);
      flush();
      check("R7 empty irq", int'(irq), 0);
      for (int i = 0; i < 16; i++) begin
        push(sweep_bit(lv, i));
        check("R5 R7 irq after push", int'(irq), int'((i + 1) >= thr));
      end
      for (int i = 0; i < 16; i++) begin
        pop_one(b);
        check("R1 R2 pop order", int'(b), int'(sweep_bit(lv, i)));
        check("R7 irq after pop", int'(irq), int'((15 - i) >= thr));
      end
    end

    // R6 overflow: drop, preserve, sticky, clear by fill_en
    level = 4'd0;
    flush();
    for (int i = 0; i < 16; i++) push(1'(i & 1));
    check("R6 full irq", int'(irq), 1);
    check("R6 no ovf yet", int'(ovf), 0);
    push(1'b0);
    check("R6 ovf set", int'(ovf), 1);
    idle(3);
    check("R6 ovf sticky", int'(ovf), 1);
    for (int i = 0; i < 16; i++) begin
      pop_one(b);
      check("R6 contents preserved", int'(b), i & 1);
    end
    level = 4'd1;
    @(negedge clk);
    check("R6 extra bit dropped", int'(irq), 0);
    check("R6 ovf after drain", int'(ovf), 1);
    pop_one(b);
    check("R2 empty pop", int'(b), 0);
    @(negedge clk); fill_en = 1'b0; @(negedge clk); fill_en = 1'b1;
    check("R6 ovf cleared by fill_en", int'(ovf), 0);

    // R8 disable flushes and clears overflow
    level = 4'd0;
    for (int i = 0; i < 17; i++) push(1'b1);
    check("R8 pre ovf", int'(ovf), 1);
    @(negedge clk); fifo_en = 1'b0;
    @(negedge clk);
    check("R8 ovf low", int'(ovf), 0);
    check("R8 irq low", int'(irq), 0);
    push(1'b1);
    level = 4'd1;
    @(negedge clk); fifo_en = 1'b1;
    @(negedge clk);
    check("R8 flushed and strobe ignored", int'(irq), 0);

    // R9 fill off keeps contents
    push(1'b1); push(1'b1); push(1'b0);
    @(negedge clk); fill_en = 1'b0;
    push(1'b1); push(1'b0); push(1'b1); push(1'b1);
    level = 4'd4; @(negedge clk);
    check("R9 no growth", int'(irq), 0);
    level = 4'd3; @(negedge clk);
    check("R9 kept", int'(irq), 1);
    pop_one(b); check("R9 pop0", int'(b), 1);
    pop_one(b); check("R9 pop1", int'(b), 1);
    pop_one(b); check("R9 pop2", int'(b), 0);
    level = 4'd1; @(negedge clk);
    check("R9 drained", int'(irq), 0);

    // R3 R4: pattern sweep, rearm via fill_en only
    fill_always = 1'b0;
    for (int pi = 0; pi < 6; pi++) begin
      logic [7:0] p;
      int k;
      case (pi)
        0: p = 8'hD4; 1: p = 8'h00; 2: p = 8'hFF;
        3: p = 8'hA5; 4: p = 8'h3C; default: p = 8'h81;
      endcase
      for (int i = 0; i < 24; i++) s[i] = 1'(((i * 7 + pi * 5) >> 2) & 1);
      for (int j = 0; j < 8; j++) begin
        s[6 + j]  = p[7 - j];
        s[15 + j] = p[7 - j];
      end
      k = -1;
      for (int i = 7; i < 24; i++) begin
        logic [7:0] w;
        for (int j = 0; j < 8; j++) w[7 - j] = s[i - 7 + j];
        if (k < 0 && w == p) k = i;
      end
      @(negedge clk); fill_en = 1'b0; pattern = p;
      @(negedge clk); fill_en = 1'b1;
      for (int i = 0; i < 24; i++) begin
        push(s[i]);
        check("R3 store starts after match", int'(irq), int'(i > k));
      end
      for (int j = 0; j < 23 - k; j++) begin
        pop_one(b);
        check("R4 data after match", int'(b), int'(s[k + 1 + j]));
      end
      check("R4 drained", int'(irq), 0);
      check("R4 no ovf", int'(ovf), 0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule